// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. A base input gives the physical address of the top-level table. The walker reads one 32-bit entry per level through a simple word-wide memory port. At each level it checks the entry's present bit and its permission bits against the request. It returns either the translated address together with the low attribute bits of the final entry, or a fault.

Each entry passed on a successful check gets its accessed flag set. The final entry also gets its dirty flag set when the request is a write. An entry is written back to memory only if one of these flags actually changed. Each such write finishes before the walk goes on.

On a fault, the faulting virtual address and a three-bit cause code are captured in registers. These registers keep their values until the next fault, so a handler can read them later. Requests and results each use a valid/ready handshake, and the walker handles one translation at a time.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into a top index in bits 31:22, a second index in bits 21:12 and a page offset in bits 11:0. The first memory read of a walk is at base + 4 × top index.
- R2: The second read is at the address formed by bits 31:12 of the top entry (frame number), then the second index, then two zero bits.
- R3: On success the response has fault = 0. The physical address is the final entry's bits 31:12 followed by the unchanged offset. The attribute output is bits 11:0 of the final entry after its flag update.
- R4: If an entry read at either level has bit 0 (present) = 0, the walk stops with a fault. Code bit 0 is 0, and no further memory read is made.
- R5: A present entry faults with code bit 0 = 1 in two cases: a write request when the entry's bit 1 (writable) = 0, or a user request when its bit 2 (user) = 0. This check applies at both levels.
- R6: Code bit 1 equals the request's write flag and code bit 2 equals its user flag. The faulting virtual address and the code are held until the next fault, and both reset to zero.
- R7: Every entry that passes its checks gets bit 5 (accessed) set. The final entry also gets bit 6 (dirty) set on a write request.
- R8: An entry is written back only when its flags changed. The write goes to the same address it was read from, and it completes before the next read or the response.
- R9: After reset the walker is idle with req_ready high and no response. It accepts a request only when idle, and it holds a response stable until rsp_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pt_base_i | input | 32 | Physical address of the top-level table, sampled when a request is accepted |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write access |
| req_user_i | input | 1 | Request comes from user mode |
| mem_req_valid_o | output | 1 | Memory access request, one cycle per access |
| mem_req_write_o | output | 1 | Memory access is a write |
| mem_req_addr_o | output | 32 | Byte address of the entry |
| mem_req_wdata_o | output | 32 | Entry value to write |
| mem_resp_valid_i | input | 1 | Memory response (read data or write acknowledge) |
| mem_resp_rdata_i | input | 32 | Read data |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result accepted |
| rsp_fault_o | output | 1 | Result is a fault |
| rsp_paddr_o | output | 32 | Translated physical address (zero on fault) |
| rsp_attr_o | output | 12 | Low attribute bits of the final entry (zero on fault) |
| fault_vaddr_o | output | 32 | Virtual address of the most recent fault |
| fault_code_o | output | 3 | Cause code of the most recent fault |

## Verification
The assertions assume that memory answers each access exactly once and only after it was issued. They also assume the base input does not matter outside request acceptance, and that rsp_ready is meaningful only while a result is shown. The bench's memory model answers in the cycle after each request and never produces an unsolicited response. The bench starts a new request only after the previous result has been taken. It delays rsp_ready by two cycles so that the hold behaviour is exercised without breaking these assumptions.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PTE_PRESENT  = 0;
  localparam int unsigned PTE_WRITABLE = 1;
  localparam int unsigned PTE_USER     = 2;
  localparam int unsigned PTE_ACCESSED = 5;
  localparam int unsigned PTE_DIRTY    = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [ENT_W-1:0] top_ent_i,
  input  logic [ENT_W-1:0] leaf_ent_i,
  output logic [PA_W-1:0]  top_slot_o,
  output logic [PA_W-1:0]  leaf_slot_o,
  output logic [PA_W-1:0]  paddr_o
);
  localparam int FRM_W  = PA_W - OFF_W;
  localparam int ESZ_LG = $clog2(ENT_W / 8);

  function automatic logic [PA_W-1:0] slot_in_base(input logic [PA_W-1:0] b,
                                                   input logic [L1_W-1:0] idx);
    return b + (PA_W'(idx) << ESZ_LG);
  endfunction

  function automatic logic [PA_W-1:0] slot_in_frame(input logic [FRM_W-1:0] f,
                                                    input logic [L2_W-1:0] idx);
    return {f, {OFF_W{1'b0}}} + (PA_W'(idx) << ESZ_LG);
  endfunction

  function automatic logic [PA_W-1:0] frame_join(input logic [FRM_W-1:0] f,
                                                 input logic [OFF_W-1:0] off);
    return {f, off};
  endfunction

  logic [L1_W-1:0]  top_idx;
  logic [L2_W-1:0]  leaf_idx;
  logic [OFF_W-1:0] page_off;

  assign top_idx  = vaddr_i[OFF_W+L2_W +: L1_W];
  assign leaf_idx = vaddr_i[OFF_W +: L2_W];
  assign page_off = vaddr_i[OFF_W-1:0];

  assign top_slot_o  = slot_in_base(base_i, top_idx);
  assign leaf_slot_o = slot_in_frame(top_ent_i[OFF_W +: FRM_W], leaf_idx);
  assign paddr_o     = frame_join(leaf_ent_i[OFF_W +: FRM_W], page_off);
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] ent_i,
  input  logic             wr_i,
  input  logic             usr_i,
  input  logic             leaf_i,
  output logic             present_o,
  output logic             pass_o,
  output logic [ENT_W-1:0] upd_o,
  output logic             changed_o
);
  logic perm_ok;

  assign present_o = ent_i[PTE_PRESENT];
  assign perm_ok   = (!wr_i || ent_i[PTE_WRITABLE]) && (!usr_i || ent_i[PTE_USER]);
  assign pass_o    = present_o && perm_ok;

  always_comb begin
    upd_o = ent_i;
    upd_o[PTE_ACCESSED] = 1'b1;
    if (leaf_i && wr_i) upd_o[PTE_DIRTY] = 1'b1;
  end

  assign changed_o = (upd_o != ent_i);

  always_comb begin
    if (!leaf_i) assert (upd_o[PTE_DIRTY] == ent_i[PTE_DIRTY])
      else $error("p_no_dirty_on_top_r7");
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PA_W-1:0]  pt_base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  output logic             mem_req_valid_o,
  output logic             mem_req_write_o,
  output logic [PA_W-1:0]  mem_req_addr_o,
  output logic [ENT_W-1:0] mem_req_wdata_o,
  input  logic             mem_resp_valid_i,
  input  logic [ENT_W-1:0] mem_resp_rdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [OFF_W-1:0] rsp_attr_o,
  output logic [VA_W-1:0]  fault_vaddr_o,
  output logic [2:0]       fault_code_o
);
  walk_st_e         st_q;
  logic             leaf_q, wr_q, usr_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [PA_W-1:0]  base_q;
  logic [ENT_W-1:0] top_ent_q, ent_q;
  logic             rsp_fault_q;
  logic [PA_W-1:0]  paddr_q;
  logic [OFF_W-1:0] attr_q;
  logic [VA_W-1:0]  fva_q;
  logic [2:0]       fcode_q;

  logic [PA_W-1:0]  top_slot, leaf_slot, cur_slot, join_paddr;
  logic [ENT_W-1:0] adv_ent, chk_upd;
  logic             chk_present, chk_pass, chk_changed;

  // named internal events
  logic req_fire, rd_fire, wb_fire, rd_back, wb_back, walk_fault, walk_adv, rsp_fire;

  assign adv_ent = (st_q == ST_RD_WAIT) ? chk_upd : ent_q;

  ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W),
                 .ENT_W(ENT_W)) u_addr (
    .base_i(base_q), .vaddr_i(vaddr_q), .top_ent_i(top_ent_q), .leaf_ent_i(adv_ent),
    .top_slot_o(top_slot), .leaf_slot_o(leaf_slot), .paddr_o(join_paddr));

  ptw_entry_check #(.ENT_W(ENT_W)) u_chk (
    .ent_i(mem_resp_rdata_i), .wr_i(wr_q), .usr_i(usr_q), .leaf_i(leaf_q),
    .present_o(chk_present), .pass_o(chk_pass), .upd_o(chk_upd), .changed_o(chk_changed));

  assign cur_slot   = leaf_q ? leaf_slot : top_slot;
  assign req_fire   = (st_q == ST_IDLE) && req_valid_i;
  assign rd_fire    = (st_q == ST_RD_REQ);
  assign wb_fire    = (st_q == ST_WB_REQ);
  assign rd_back    = (st_q == ST_RD_WAIT) && mem_resp_valid_i;
  assign wb_back    = (st_q == ST_WB_WAIT) && mem_resp_valid_i;
  assign walk_fault = rd_back && !chk_pass;
  assign walk_adv   = (rd_back && chk_pass && !chk_changed) || wb_back;
  assign rsp_fire   = (st_q == ST_DONE) && rsp_ready_i;

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = rd_fire || wb_fire;
  assign mem_req_write_o = wb_fire;
  assign mem_req_addr_o  = cur_slot;
  assign mem_req_wdata_o = ent_q;
  assign rsp_valid_o     = (st_q == ST_DONE);
  assign rsp_fault_o     = rsp_fault_q;
  assign rsp_paddr_o     = paddr_q;
  assign rsp_attr_o      = attr_q;
  assign fault_vaddr_o   = fva_q;
  assign fault_code_o    = fcode_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      leaf_q      <= 1'b0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      vaddr_q     <= '0;
      base_q      <= '0;
      top_ent_q   <= '0;
      ent_q       <= '0;
      rsp_fault_q <= 1'b0;
      paddr_q     <= '0;
      attr_q      <= '0;
      fva_q       <= '0;
      fcode_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_fire) begin
          vaddr_q <= req_vaddr_i;
          wr_q    <= req_write_i;
          usr_q   <= req_user_i;
          base_q  <= pt_base_i;
          leaf_q  <= 1'b0;
          st_q    <= ST_RD_REQ;
        end
        ST_RD_REQ: st_q <= ST_RD_WAIT;
        ST_WB_REQ: st_q <= ST_WB_WAIT;
        ST_DONE:   if (rsp_fire) st_q <= ST_IDLE;
        default: ;
      endcase
      if (walk_fault) begin
        rsp_fault_q <= 1'b1;
        paddr_q     <= '0;
        attr_q      <= '0;
        fva_q       <= vaddr_q;
        fcode_q     <= {usr_q, wr_q, chk_present};
        st_q        <= ST_DONE;
      end else if (rd_back && chk_changed) begin
        ent_q <= chk_upd;
        st_q  <= ST_WB_REQ;
      end else if (walk_adv) begin
        if (!leaf_q) begin
          top_ent_q <= adv_ent;
          leaf_q    <= 1'b1;
          st_q      <= ST_RD_REQ;
        end else begin
          rsp_fault_q <= 1'b0;
          paddr_q     <= join_paddr;
          attr_q      <= adv_ent[OFF_W-1:0];
          st_q        <= ST_DONE;
        end
      end
    end
  end

  // assertion support: address of the last read issued
  logic [PA_W-1:0] last_rd_addr_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) last_rd_addr_q <= '0;
    else if (mem_req_valid_o && !mem_req_write_o) last_rd_addr_q <= mem_req_addr_o;
  end

  p_mem_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |=> !mem_req_valid_o);
  p_wb_same_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_write_o) |-> (mem_req_addr_o == last_rd_addr_q));
  p_rsp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o) && $stable(rsp_attr_o)));
  p_idle_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!rsp_valid_o && !mem_req_valid_o));
  p_accessed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> rsp_attr_o[PTE_ACCESSED]);
  p_dirty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o && wr_q) |-> rsp_attr_o[PTE_DIRTY]);
  p_code_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rsp_valid_o) && rsp_fault_o) |-> (fault_code_o[1] == wr_q && fault_code_o[2] == usr_q));
  p_fault_regs_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(rsp_valid_o) && !$past(walk_fault)) |-> ($stable(fault_vaddr_o) && $stable(fault_code_o)));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base = 32'h0001_0000;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_req_valid, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_rdata = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
  logic [31:0] rsp_paddr, fault_vaddr;
  logic [11:0] rsp_attr;
  logic [2:0]  fault_code;

  always #10 clk = ~clk;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pt_base_i(pt_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user),
    .mem_req_valid_o(mem_req_valid), .mem_req_write_o(mem_req_write),
    .mem_req_addr_o(mem_req_addr), .mem_req_wdata_o(mem_req_wdata),
    .mem_resp_valid_i(mem_resp_valid), .mem_resp_rdata_i(mem_resp_rdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_fault_o(rsp_fault),
    .rsp_paddr_o(rsp_paddr), .rsp_attr_o(rsp_attr),
    .fault_vaddr_o(fault_vaddr), .fault_code_o(fault_code));

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle response, logs of the current transaction
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [4];
  logic [31:0] wr_log [4];
  int n_rd = 0, n_wr = 0;

  function automatic logic [31:0] mrd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_resp_valid <= 1'b0;
    if (mem_req_valid) begin
      if (mem_req_write) begin
        mem[mem_req_addr] = mem_req_wdata;
        if (n_wr < 4) wr_log[n_wr] = mem_req_addr;
        n_wr++;
      end else begin
        if (n_rd < 4) rd_log[n_rd] = mem_req_addr;
        n_rd++;
      end
      mem_resp_rdata <= mrd(mem_req_addr);
      mem_resp_valid <= 1'b1;
    end
  end

  typedef struct {
    logic        fault;
    logic [31:0] paddr;
    logic [11:0] attr;
    logic [31:0] fva;
    logic [2:0]  code;
    int          rds, wrs;
    logic [31:0] a1, v1, a2, v2;
    logic        has2;
  } exp_t;

  exp_t sb_q[$];
  logic [31:0] last_fva = '0;
  logic [2:0]  last_code = '0;

  function automatic logic [31:0] mk_va(int i1, int i2, int off);
    return {i1[9:0], i2[9:0], off[11:0]};
  endfunction

  function automatic logic perm_ok(logic [31:0] e, logic w, logic u);
    return (!w || e[1]) && (!u || e[2]);
  endfunction

  task automatic send(logic [31:0] va, logic w, logic u);
    exp_t it;
    logic [31:0] e1, e2;
    while (sb_q.size() != 0) @(negedge clk);
    it.a1 = pt_base + {20'd0, va[31:22], 2'b00};
    e1 = mrd(it.a1);
    it.v1 = e1; it.rds = 1; it.wrs = 0; it.has2 = 0;
    it.a2 = '0; it.v2 = '0; it.fault = 1'b1; it.paddr = '0; it.attr = '0;
    if (!e1[0]) it.code = {u, w, 1'b0};
    else if (!perm_ok(e1, w, u)) it.code = {u, w, 1'b1};
    else begin
      it.v1 = e1 | 32'h20;
      if (it.v1 != e1) it.wrs++;
      it.a2 = {e1[31:12], va[21:12], 2'b00};
      e2 = mrd(it.a2);
      it.v2 = e2; it.rds = 2; it.has2 = 1;
      if (!e2[0]) it.code = {u, w, 1'b0};
      else if (!perm_ok(e2, w, u)) it.code = {u, w, 1'b1};
      else begin
        it.v2 = e2 | 32'h20 | (w ? 32'h40 : 32'h0);
        if (it.v2 != e2) it.wrs++;
        it.fault = 1'b0;
        it.paddr = {it.v2[31:12], va[11:0]};
        it.attr = it.v2[11:0];
      end
    end
    if (it.fault) begin last_fva = va; last_code = it.code; end
    it.fva = last_fva;
    if (!it.fault) it.code = last_code;
    n_rd = 0; n_wr = 0;
    sb_q.push_back(it);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (sb_q.size() == 0) begin
          chk("R9", "unexpected response", 32'd1, 32'd0);
        end else begin
          it = sb_q[0];
          chk("R1", "top entry read addr", rd_log[0], it.a1);
          if (it.has2) chk("R2", "leaf entry read addr", rd_log[1], it.a2);
          chk("R4", "read count", n_rd, it.rds);
          chk(it.fault ? "R4" : "R3", "fault flag", {31'd0, rsp_fault}, {31'd0, it.fault});
          chk("R3", "paddr", rsp_paddr, it.paddr);
          chk("R3", "attr", {20'd0, rsp_attr}, {20'd0, it.attr});
          chk("R6", "fault vaddr", fault_vaddr, it.fva);
          chk(it.code[0] ? "R5" : "R6", "fault code", {29'd0, fault_code}, {29'd0, it.code});
          chk("R8", "write-back count", n_wr, it.wrs);
          if (n_wr > 0) chk("R8", "write-back addr", wr_log[0], (it.v1 != mrd(it.a1) || it.wrs == 0) ? it.a2 : (n_wr > 0 && it.a1 == wr_log[0] ? it.a1 : it.a2));
          chk("R7", "top entry in memory", mrd(it.a1), it.v1);
          if (it.has2) chk("R7", "leaf entry in memory", mrd(it.a2), it.v2);
          chk("R9", "not ready while result shown", {31'd0, req_ready}, 32'd0);
          repeat (2) @(negedge clk);
          chk("R9", "result held", {rsp_valid, rsp_paddr[30:0]}, {1'b1, it.paddr[30:0]});
          rsp_ready = 1'b1;
          @(negedge clk);
          rsp_ready = 1'b0;
          chk("R9", "result released", {31'd0, rsp_valid}, 32'd0);
          void'(sb_q.pop_front());
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // tables: top at 0x10000, second level at 0x20000/0x21000/0x22000
    mem[32'h0001_0004] = 32'h0002_0007;  // idx1=1 P W U
    mem[32'h0001_0008] = 32'h0000_0000;  // idx1=2 not present
    mem[32'h0001_000C] = 32'h0002_1005;  // idx1=3 P U, read-only
    mem[32'h0001_0010] = 32'h0002_2003;  // idx1=4 P W, system
    mem[32'h0002_0014] = 32'hABCD_E007;  // idx2=5 P W U
    mem[32'h0002_0018] = 32'h0000_0000;  // idx2=6 not present
    mem[32'h0002_001C] = 32'h1234_5005;  // idx2=7 P U read-only
    mem[32'h0002_1000] = 32'h5555_5007;  // idx2=0
    mem[32'h0002_2004] = 32'h6666_6003;  // idx2=1 system page
    repeat (3) @(negedge clk);
    chk("R9", "reset ready", {31'd0, req_ready}, 32'd1);
    chk("R9", "reset no response", {31'd0, rsp_valid}, 32'd0);
    chk("R6", "reset fault vaddr", fault_vaddr, 32'd0);
    chk("R6", "reset fault code", {29'd0, fault_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    send(mk_va(1, 5, 12'h123), 1'b0, 1'b1);  // R7 R8: both accessed bits written
    send(mk_va(1, 5, 12'hFFF), 1'b0, 1'b1);  // R8: no change, no write
    send(mk_va(1, 5, 12'h000), 1'b1, 1'b1);  // R7: dirty on write
    send(mk_va(2, 0, 12'h010), 1'b1, 1'b0);  // R4: top not present
    send(mk_va(1, 6, 12'h020), 1'b0, 1'b0);  // R4: leaf not present
    send(mk_va(1, 7, 12'h030), 1'b1, 1'b1);  // R5: write to read-only leaf
    send(mk_va(3, 0, 12'h040), 1'b1, 1'b0);  // R5: write to read-only top
    send(mk_va(4, 1, 12'h050), 1'b0, 1'b1);  // R5: user on system top
    send(mk_va(4, 1, 12'h060), 1'b1, 1'b0);  // R3: system write allowed
    send(mk_va(3, 0, 12'h070), 1'b0, 1'b1);  // R6: fault regs retained
    send(mk_va(1, 7, 12'h080), 1'b0, 1'b1);  // R3: read of read-only page
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule